// File: doc/BRIEF.md
# Table-driven PWM pulse train generator

This block emits a finite burst of edge-aligned PWM pulses on a single output pin. A free-running up-counter runs from zero to a modulo value that is captured when the burst begins, giving a fixed period of modulo plus one clocks. The high time of every period comes from a stream of compare values. These values are fetched one at a time through a request/acknowledge load port, which stands in for a DMA engine or any other memory-to-peripheral mover.

A single pulse on `start` begins a burst. The first table entry is fetched into the active compare register before the counter begins. Each entry after that is fetched during the period before the one it applies to and is held in a shadow register. It moves into the active register only at the counter wrap. As a result, each entry covers exactly one full period and none is skipped or repeated.

After the number of entries given by `burst_len` has been fetched, requests stop. When the period that used the final entry ends, the block raises `done`. A terminating entry of zero therefore leaves the pin parked low.

Top module: `pwm_burst_gen`

## Requirements
- R1: After reset, `pwm_out`, `ld_req`, `busy` and `done` are 0. `pwm_out` is 0 in every cycle in which `busy` is 0.
- R2: While a burst runs, the counter stays within 0..modulo, and consecutive period starts are exactly `mod_val`+1 clocks apart. `mod_val` is sampled in the cycle the burst starts.
- R3: A period whose active compare value is C drives `pwm_out` high for exactly C consecutive clocks from the period start, then low. When C is 0 the period has no pulse. Compare values must not exceed the modulo.
- R4: While the block is idle, a `start` pulse with nonzero `burst_len` makes it busy and raises `ld_req` for the first entry before any period is counted. A `start` with `burst_len` equal to 0 is ignored.
- R5: `ld_req` rises in the cycle after the counter equals the active compare value, provided entries remain unfetched and no value is buffered. It stays high until a cycle with `ld_ack` high, and falls in the next cycle. Each handshake transfers one entry, and exactly `burst_len` handshakes occur per burst.
- R6: Entries apply in fetch order, one per period, switching only at the counter wrap. Every nonzero entry yields exactly one pulse.
- R7: If no value is buffered at a wrap while entries remain, the next period runs with compare 0 (no pulse) and `late` is set. The late entry applies to the period after that. `late` stays set until the next burst starts.
- R8: When the period that used the final entry ends, `busy` falls and `done` rises. `done` stays high until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a burst (one-cycle pulse, accepted when idle) |
| mod_val | input | CNT_W | Counter modulo; the period is mod_val+1 clocks |
| burst_len | input | LEN_W | Number of table entries in the burst |
| ld_req | output | 1 | Request for the next compare value |
| ld_ack | input | 1 | Acknowledge; ld_data is valid in this cycle |
| ld_data | input | CNT_W | Compare value being delivered |
| pwm_out | output | 1 | Edge-aligned PWM output |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Last burst completed |
| late | output | 1 | A value arrived after its wrap during this burst |

## Verification
The main sequence is a 25-entry table: sixteen entries of 8, eight of 15, and a closing 0. This exposes a lost or duplicated first pulse, which is the classic preload fault. Random tables with random moduli and responder latencies check that every width, the period spacing and the handshake count follow the table for arbitrary contents, rather than for one repeated value. A slow responder paired with wide pulses forces every fetch past its wrap, which separates correct late handling (a blank period, then the same entry, no duplicate) from a design that would repeat the old width. A zero-length start and the idle intervals between bursts check that no spurious pulse or request appears.

// File: rtl/pwm_burst_pkg.sv
package pwm_burst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } burst_state_t;
endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] mod_lim,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = run && (cnt == mod_lim);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_reload_buf.sv
module pwm_reload_buf #(
  parameter int CNT_W = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_burst,
  input  logic             in_load,
  input  logic             in_run,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [LEN_W-1:0] burst_len,
  input  logic             ld_ack,
  input  logic [CNT_W-1:0] ld_data,
  output logic             ld_req,
  output logic [CNT_W-1:0] cmp_act,
  output logic             exhausted,
  output logic             late
);
  logic [LEN_W-1:0] remaining;
  logic [CNT_W-1:0] shadow;
  logic             shadow_v;
  logic             ack_ok;
  logic             fetch_now;

  assign ack_ok    = ld_ack && ld_req;
  assign exhausted = (remaining == '0) && !shadow_v;
  assign fetch_now = in_run && (cnt == cmp_act) && (remaining != '0)
                     && !shadow_v && !ld_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_req <= 1'b0;
    end else if (start_burst) begin
      ld_req <= 1'b1;
    end else if (ack_ok) begin
      ld_req <= 1'b0;
    end else if (fetch_now) begin
      ld_req <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      shadow    <= '0;
      shadow_v  <= 1'b0;
      cmp_act   <= '0;
      late      <= 1'b0;
    end else if (start_burst) begin
      remaining <= burst_len;
      shadow_v  <= 1'b0;
      cmp_act   <= '0;
      late      <= 1'b0;
    end else begin
      if (ack_ok) begin
        remaining <= remaining - 1'b1;
      end
      if (in_load && ack_ok) begin
        cmp_act <= ld_data;
      end else if (in_run) begin
        if (ack_ok) begin
          shadow   <= ld_data;
          shadow_v <= 1'b1;
        end else if (wrap) begin
          shadow_v <= 1'b0;
        end
        if (wrap) begin
          if (shadow_v) begin
            cmp_act <= shadow;
          end else if (remaining != '0) begin
            cmp_act <= '0;
            late    <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pwm_burst_gen.sv
module pwm_burst_gen
  import pwm_burst_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] mod_val,
  input  logic [LEN_W-1:0] burst_len,
  output logic             ld_req,
  input  logic             ld_ack,
  input  logic [CNT_W-1:0] ld_data,
  output logic             pwm_out,
  output logic             busy,
  output logic             done,
  output logic             late
);
  burst_state_t     state;
  logic [CNT_W-1:0] mod_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_act;
  logic             wrap;
  logic             exhausted;
  logic             start_burst;
  logic             in_load;
  logic             in_run;

  assign start_burst = (state == ST_IDLE) && start && (burst_len != '0);
  assign in_load     = (state == ST_LOAD);
  assign in_run      = (state == ST_RUN);
  assign busy        = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      mod_q <= '0;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start_burst) begin
          state <= ST_LOAD;
          mod_q <= mod_val;
          done  <= 1'b0;
        end
        ST_LOAD: if (ld_ack && ld_req) begin
          state <= ST_RUN;
        end
        ST_RUN: if (wrap && exhausted) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  pwm_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .run    (in_run),
    .mod_lim(mod_q),
    .cnt    (cnt_q),
    .wrap   (wrap)
  );

  pwm_reload_buf #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_buf (
    .clk        (clk),
    .rst        (rst),
    .start_burst(start_burst),
    .in_load    (in_load),
    .in_run     (in_run),
    .wrap       (wrap),
    .cnt        (cnt_q),
    .burst_len  (burst_len),
    .ld_ack     (ld_ack),
    .ld_data    (ld_data),
    .ld_req     (ld_req),
    .cmp_act    (cmp_act),
    .exhausted  (exhausted),
    .late       (late)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out <= 1'b0;
    end else begin
      pwm_out <= in_run && (cnt_q < cmp_act);
    end
  end
endmodule

// File: rtl/pwm_burst_gen_chk.sv
module pwm_burst_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             pwm_out,
  input logic             busy,
  input logic             done,
  input logic             ld_req,
  input logic             ld_ack,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] mod_q
);
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !pwm_out); // R1
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= mod_q); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ld_req && !ld_ack) |=> ld_req); // R5
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (ld_req && ld_ack) |=> !ld_req); // R5
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ld_req); // R5
  AST_DONE_END: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !busy); // R8
endmodule

bind pwm_burst_gen pwm_burst_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .pwm_out(pwm_out),
  .busy   (busy),
  .done   (done),
  .ld_req (ld_req),
  .ld_ack (ld_ack),
  .cnt    (cnt_q),
  .mod_q  (mod_q)
);

// File: tb/pwm_burst_gen_bench.sv
`timescale 1ns/1ps
module pwm_burst_gen_bench;
  localparam int CW = 16;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [CW-1:0] mod_val;
  logic [LW-1:0] burst_len;
  logic          ld_req;
  logic          ld_ack;
  logic [CW-1:0] ld_data;
  logic          pwm_out;
  logic          busy;
  logic          done;
  logic          late;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [15:0] tbl [64];
  int rsp_lat = 0;
  int rsp_idx = 0;
  int wid [64];
  int rise [64];
  int npl = 0;
  int hi = 0;
  bit idle_hi = 0;

  always #2.5 clk = ~clk;

  pwm_burst_gen #(.CNT_W(CW), .LEN_W(LW)) u_pwm_burst_gen (
    .clk(clk), .rst(rst), .start(start), .mod_val(mod_val),
    .burst_len(burst_len), .ld_req(ld_req), .ld_ack(ld_ack),
    .ld_data(ld_data), .pwm_out(pwm_out), .busy(busy), .done(done),
    .late(late)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // load-port responder
  initial begin
    ld_ack = 1'b0;
    ld_data = '0;
    forever begin
      @(negedge clk);
      if (ld_req && !ld_ack) begin
        repeat (rsp_lat) @(negedge clk);
        ld_data = tbl[rsp_idx];
        ld_ack = 1'b1;
        rsp_idx++;
        @(negedge clk);
        ld_ack = 1'b0;
      end
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (pwm_out) begin
        if (hi == 0 && npl < 64) rise[npl] = cyc;
        hi++;
        if (!busy) idle_hi = 1;
      end else if (hi > 0) begin
        if (npl < 64) wid[npl] = hi;
        npl++;
        hi = 0;
      end
    end
  end

  function automatic int count_nonzero(input int n);
    int k = 0;
    for (int i = 0; i < n; i++) if (tbl[i] != 0) k++;
    return k;
  endfunction

  task automatic run_burst(input int n, input int m, input int lat, input bit exp_late);
    int k;
    int j;
    int t;
    mod_val = CW'(m);
    burst_len = LW'(n);
    rsp_lat = lat;
    rsp_idx = 0;
    npl = 0;
    hi = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R4 busy after start", int'(busy), 1);
    check(ld_req == 1'b1 && pwm_out == 1'b0, "R4 preload request", int'(ld_req), 1);
    t = 0;
    while (busy && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    k = count_nonzero(n);
    check(npl == k, "R6 pulse count", npl, k);
    j = 0;
    for (int i = 0; i < n; i++) begin
      if (tbl[i] != 0) begin
        if (j < 64) check(wid[j] == int'(tbl[i]), "R3 pulse width", wid[j], int'(tbl[i]));
        j++;
      end
    end
    if (!exp_late) begin
      for (int i = 1; i < k && i < 64; i++)
        check(rise[i] - rise[i-1] == m + 1, "R2 period spacing", rise[i] - rise[i-1], m + 1);
    end
    check(done == 1'b1 && busy == 1'b0, "R8 done at end", int'(done), 1);
    check(late == exp_late, "R7 late flag", int'(late), int'(exp_late));
    check(rsp_idx == n, "R5 handshake count", rsp_idx, n);
    check(idle_hi == 0, "R1 no pulse while idle", int'(idle_hi), 0);
  endtask

  // watchdog
  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_sim();
  end

  initial begin
    int m;
    int n;
    void'($urandom(32'd7));
    rst = 1'b1;
    start = 1'b0;
    mod_val = CW'(29);
    burst_len = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pwm_out == 1'b0, "R1 reset pwm_out", int'(pwm_out), 0);
    check(ld_req == 1'b0, "R1 reset ld_req", int'(ld_req), 0);
    check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    check(done == 1'b0, "R1 reset done", int'(done), 0);

    // zero-length start is ignored (R4)
    burst_len = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    check(busy == 1'b0 && ld_req == 1'b0, "R4 zero length ignored", int'(busy), 0);
    check(npl == 0 && pwm_out == 1'b0, "R1 no pulse after ignored start", npl, 0);

    // reference burst: 16 x 8, 8 x 15, terminating 0
    for (int i = 0; i < 16; i++) tbl[i] = 16'd8;
    for (int i = 16; i < 24; i++) tbl[i] = 16'd15;
    tbl[24] = 16'd0;
    run_burst(25, 29, 1, 1'b0);

    // width-1 and minimum-modulo corner
    for (int i = 0; i < 5; i++) tbl[i] = 16'd1;
    tbl[5] = 16'd0;
    run_burst(6, 7, 0, 1'b0);

    // random tables
    for (int r = 0; r < 6; r++) begin
      m = 12 + int'($urandom % 30);
      n = 2 + int'($urandom % 20);
      for (int i = 0; i < n - 1; i++) tbl[i] = 16'(1 + ($urandom % (m - 6)));
      tbl[n-1] = 16'd0;
      run_burst(n, m, int'($urandom % 3), 1'b0);
    end

    // slow responder: every fetch lands after its wrap (R7)
    for (int i = 0; i < 5; i++) tbl[i] = 16'd27;
    tbl[5] = 16'd0;
    run_burst(6, 29, 6, 1'b1);

    // next burst clears late (R7)
    for (int i = 0; i < 3; i++) tbl[i] = 16'd4;
    tbl[3] = 16'd0;
    run_burst(4, 20, 0, 1'b0);

    finish_sim();
  end
endmodule